// File: doc/BRIEF.md
# SDRAM Command Spacing and Refresh Guard

This block sits in front of the command bus of a four-bank SDRAM. A command issuer presents one command per cycle with a code and a bank number. The guard holds the minimum spacings between commands, set by configuration inputs, and tells the issuer through one "allowed" output per command kind whether that command may go out in the current cycle. A command counts as accepted only when `cmd_valid` is high and the matching allowed output is high. Each accepted command reloads the spacing counters it starts. Every counter then counts down once per clock, and a later command is allowed only when all counters that guard it have reached zero.

The guard also tracks which of the four banks holds an open row, because reads and writes need an open bank and activates need a closed one. A periodic refresh timer runs while its enable is high. Its interval is a count in units of 64 clocks. When the interval ends, the timer raises a refresh request that stays high until the issuer gets a refresh command accepted.

Top module: `sdram_cmd_guard`

## Requirements
- R1: After reset no bank is open, every counter is zero and `ref_req` is low. So `ok_act`, `ok_pre`, `ok_prea` and `ok_ref` are high and `ok_rd` and `ok_wr` are low.
- R2: A read or write is allowed only to an open bank. After an activate to bank b is accepted in cycle t, a read or write to b is allowed no earlier than cycle t + `cfg_act2rw` + 1.
- R3: An activate is allowed only to a closed bank. After a precharge that covers bank b is accepted in cycle t, an activate to b is allowed no earlier than cycle t + `cfg_pre2act` + 1.
- R4: `cfg_ref2act` is in units of two clocks. After a refresh is accepted in cycle t, neither an activate nor a refresh is allowed before cycle t + max(2·`cfg_ref2act`, 1). A refresh also needs all banks closed, with no precharge-to-activate spacing still running.
- R5: After a read to bank b is accepted in cycle t, a precharge covering b is allowed no earlier than cycle t + max(`cfg_rd2pre`, 1).
- R6: After any read is accepted in cycle t, a write is allowed no earlier than cycle t + max(`cfg_rd2wr`, 1).
- R7: After a write to bank b is accepted in cycle t, a precharge covering b is allowed no earlier than cycle t + max(`cfg_wr2pre`, 1).
- R8: Open state and per-bank spacings are held separately for each of the four banks selected by the 2-bit `cmd_bank`. A command to one bank does not change what is allowed for another bank, except through the shared read-to-write and refresh spacings.
- R9: Precharge-all (code 5) is allowed only when no bank has a read- or write-to-precharge spacing running. It closes all banks and starts the precharge-to-activate spacing on every bank.
- R10: While `cfg_ref_en` stays high, `ref_req` rises exactly (`cfg_ref_cnt`+1)·64 clock edges after the enable was first seen high.
- R11: Once high, `ref_req` stays high until a refresh is accepted. It is low in the cycle after that acceptance, unless the interval ends in that same cycle.
- R12: While `cfg_ref_en` is low the timer is held at zero and no new request is raised. After it goes high again, a full interval elapses before the next request.
- R13: Command codes: 0 no-op, 1 activate, 2 read, 3 write, 4 precharge one bank, 5 precharge all, 6 refresh, 7 unused. Codes 0 and 7 change no state even when `cmd_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Issuer presents a command this cycle |
| cmd_code | input | 3 | Command code (R13) |
| cmd_bank | input | 2 | Target bank |
| cfg_act2rw | input | 4 | Activate to read/write spacing minus one |
| cfg_pre2act | input | 4 | Precharge to activate spacing minus one |
| cfg_ref2act | input | 4 | Refresh to activate spacing in pairs of clocks |
| cfg_rd2pre | input | 4 | Read to precharge spacing in clocks |
| cfg_rd2wr | input | 4 | Read to write spacing in clocks |
| cfg_wr2pre | input | 4 | Write to precharge spacing in clocks |
| cfg_ref_en | input | 1 | Periodic refresh timer enable |
| cfg_ref_cnt | input | 4 | Refresh interval count, units of 64 clocks |
| ok_act | output | 1 | Activate to `cmd_bank` allowed |
| ok_rd | output | 1 | Read to `cmd_bank` allowed |
| ok_wr | output | 1 | Write to `cmd_bank` allowed |
| ok_pre | output | 1 | Precharge of `cmd_bank` allowed |
| ok_prea | output | 1 | Precharge of all banks allowed |
| ok_ref | output | 1 | Refresh allowed |
| ref_req | output | 1 | Refresh request pending |

## Verification
The bench sweeps every value of each spacing field. For each value it measures the cycle in which the guarded command first becomes allowed after its starting command. An off-by-one in a reload value would show up as a spacing one cycle short or long. A missing doubling of the refresh field would halve that gap. A field taken as zero would let the command through at once. Bank separation and precharge-all are checked by looking at other banks through `cmd_bank` right after a command. A design that shares state across banks would block, or open, the wrong bank. The refresh timer is timed for several counts and across a disable that restarts it. A request that clears by itself, or a timer that keeps its count through a disable, would show up as a wrong edge count or an early drop of `ref_req`.

// File: rtl/sdram_cmd_guard.sv
module sdram_cmd_guard #(
  parameter int FW       = 4,
  parameter int RCW      = 4,
  parameter int REF_UNIT = 64,
  parameter int BANKS    = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_valid,
  input  logic [2:0]               cmd_code,
  input  logic [$clog2(BANKS)-1:0] cmd_bank,
  input  logic [FW-1:0]            cfg_act2rw,
  input  logic [FW-1:0]            cfg_pre2act,
  input  logic [FW-1:0]            cfg_ref2act,
  input  logic [FW-1:0]            cfg_rd2pre,
  input  logic [FW-1:0]            cfg_rd2wr,
  input  logic [FW-1:0]            cfg_wr2pre,
  input  logic                     cfg_ref_en,
  input  logic [RCW-1:0]           cfg_ref_cnt,
  output logic                     ok_act,
  output logic                     ok_rd,
  output logic                     ok_wr,
  output logic                     ok_pre,
  output logic                     ok_prea,
  output logic                     ok_ref,
  output logic                     ref_req
);
  localparam int CW = FW + 1;
  localparam int UW = $clog2(REF_UNIT);
  localparam int TW = UW + RCW;

  localparam logic [2:0] C_ACT  = 3'd1;
  localparam logic [2:0] C_RD   = 3'd2;
  localparam logic [2:0] C_WR   = 3'd3;
  localparam logic [2:0] C_PRE  = 3'd4;
  localparam logic [2:0] C_PREA = 3'd5;
  localparam logic [2:0] C_REF  = 3'd6;

  function automatic logic [CW-1:0] down(input logic [CW-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  logic [BANKS-1:0] open_q, act_run, pre_run, pre_busy;
  logic [CW-1:0]    rdwr_q, refa_q;
  logic [TW-1:0]    tmr_q;

  wire do_act  = cmd_valid && cmd_code == C_ACT  && ok_act;
  wire do_rd   = cmd_valid && cmd_code == C_RD   && ok_rd;
  wire do_wr   = cmd_valid && cmd_code == C_WR   && ok_wr;
  wire do_pre  = cmd_valid && cmd_code == C_PRE  && ok_pre;
  wire do_prea = cmd_valid && cmd_code == C_PREA && ok_prea;
  wire do_ref  = cmd_valid && cmd_code == C_REF  && ok_ref;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [CW-1:0] act_q, pre_q, rdp_q, wrp_q;
    wire hit = cmd_bank == b;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        open_q[b] <= 1'b0;
        act_q     <= '0;
        pre_q     <= '0;
        rdp_q     <= '0;
        wrp_q     <= '0;
      end else begin
        if (do_act && hit)                    open_q[b] <= 1'b1;
        else if ((do_pre && hit) || do_prea)  open_q[b] <= 1'b0;
        act_q <= (do_act && hit) ? {1'b0, cfg_act2rw} : down(act_q);
        pre_q <= ((do_pre && hit) || do_prea) ? {1'b0, cfg_pre2act} : down(pre_q);
        rdp_q <= (do_rd && hit) ? down({1'b0, cfg_rd2pre}) : down(rdp_q);
        wrp_q <= (do_wr && hit) ? down({1'b0, cfg_wr2pre}) : down(wrp_q);
      end
    end

    assign act_run[b]  = |act_q;
    assign pre_run[b]  = |pre_q;
    assign pre_busy[b] = |rdp_q || |wrp_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdwr_q <= '0;
      refa_q <= '0;
    end else begin
      rdwr_q <= do_rd  ? down({1'b0, cfg_rd2wr})  : down(rdwr_q);
      refa_q <= do_ref ? down({cfg_ref2act, 1'b0}) : down(refa_q);
    end
  end

  assign ok_act  = !open_q[cmd_bank] && !pre_run[cmd_bank] && refa_q == '0;
  assign ok_rd   = open_q[cmd_bank] && !act_run[cmd_bank];
  assign ok_wr   = ok_rd && rdwr_q == '0;
  assign ok_pre  = !pre_busy[cmd_bank];
  assign ok_prea = ~|pre_busy;
  assign ok_ref  = ~|open_q && ~|pre_run && refa_q == '0;

  wire [TW-1:0] tmr_last = {cfg_ref_cnt, {UW{1'b1}}};
  wire          expire   = cfg_ref_en && tmr_q == tmr_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmr_q   <= '0;
      ref_req <= 1'b0;
    end else begin
      if (!cfg_ref_en || expire) tmr_q <= '0;
      else                       tmr_q <= tmr_q + 1'b1;
      if (expire)      ref_req <= 1'b1;
      else if (do_ref) ref_req <= 1'b0;
    end
  end
endmodule

module sdram_cmd_guard_chk #(
  parameter int FW = 4,
  parameter int BW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic [2:0]    cmd_code,
  input logic [BW-1:0] cmd_bank,
  input logic [FW-1:0] cfg_act2rw,
  input logic [FW-1:0] cfg_pre2act,
  input logic          cfg_ref_en,
  input logic          ok_act,
  input logic          ok_rd,
  input logic          ok_wr,
  input logic          ok_ref,
  input logic          ref_req
);
  wire acc_act = cmd_valid && cmd_code == 3'd1 && ok_act;
  wire acc_pre = cmd_valid && cmd_code == 3'd4;
  wire acc_ref = cmd_valid && cmd_code == 3'd6 && ok_ref;

  AST_ACT_BLOCKS_RD: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_act && cfg_act2rw != '0) |=> !(ok_rd && cmd_bank == $past(cmd_bank))); // R2
  AST_PRE_BLOCKS_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_pre && cfg_pre2act != '0) |=> !(ok_act && cmd_bank == $past(cmd_bank))); // R3
  AST_REF_NO_OPEN: assert property (@(posedge clk) disable iff (!rst_n) ok_ref |-> !ok_rd); // R4
  AST_WR_AFTER_RD_GATE: assert property (@(posedge clk) disable iff (!rst_n) ok_wr |-> ok_rd); // R6
  AST_BANK_OPEN_XOR: assert property (@(posedge clk) disable iff (!rst_n) !(ok_act && ok_rd)); // R8
  AST_REQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && !acc_ref) |=> ref_req); // R11
  AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_req) |-> $past(cfg_ref_en)); // R12
endmodule

bind sdram_cmd_guard sdram_cmd_guard_chk #(.FW(FW), .BW($clog2(BANKS))) i_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
  .cmd_bank(cmd_bank), .cfg_act2rw(cfg_act2rw), .cfg_pre2act(cfg_pre2act),
  .cfg_ref_en(cfg_ref_en), .ok_act(ok_act), .ok_rd(ok_rd), .ok_wr(ok_wr),
  .ok_ref(ok_ref), .ref_req(ref_req)
);

// File: tb/test_sdram_cmd_guard.sv
`timescale 1ns/1ps
module test_sdram_cmd_guard;
  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0;
  logic [2:0] cmd_code = 0;
  logic [1:0] cmd_bank = 0;
  logic [3:0] cfg_act2rw = 0, cfg_pre2act = 0, cfg_ref2act = 0;
  logic [3:0] cfg_rd2pre = 0, cfg_rd2wr = 0, cfg_wr2pre = 0, cfg_ref_cnt = 0;
  logic cfg_ref_en = 0;
  logic ok_act, ok_rd, ok_wr, ok_pre, ok_prea, ok_ref, ref_req;
  int nchk = 0, nfail = 0;
  int n;

  always #4 clk = ~clk;

  sdram_cmd_guard i_sdram_cmd_guard (.*);

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic okof(input logic [2:0] c);
    case (c)
      3'd1: return ok_act;
      3'd2: return ok_rd;
      3'd3: return ok_wr;
      3'd4: return ok_pre;
      3'd5: return ok_prea;
      3'd6: return ok_ref;
      default: return 1'b1;
    endcase
  endfunction

  task automatic issue(input logic [2:0] c, input logic [1:0] b);
    @(negedge clk);
    cmd_code = c; cmd_bank = b; cmd_valid = 1;
    #1;
    while (!okof(c)) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic meas(input logic [2:0] c, input logic [1:0] b, output int cnt);
    cmd_code = c; cmd_bank = b; cmd_valid = 0;
    cnt = 1;
    #1;
    while (!okof(c) && cnt < 200) begin @(negedge clk); #1; cnt++; end
  endtask

  task automatic look(input logic [2:0] c, input logic [1:0] b, output int v);
    cmd_code = c; cmd_bank = b; cmd_valid = 0;
    #1;
    v = okof(c);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: got 1 expected 0");
    summary();
  end

  initial begin
    int v;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    // R1 reset state
    check("R1 ok_act", ok_act, 1); check("R1 ok_rd", ok_rd, 0);
    check("R1 ok_wr", ok_wr, 0);   check("R1 ok_pre", ok_pre, 1);
    check("R1 ok_prea", ok_prea, 1); check("R1 ok_ref", ok_ref, 1);
    check("R1 ref_req", ref_req, 0);

    // R2 / R3 sweep
    for (int f = 0; f < 16; f++) begin
      cfg_act2rw = f; cfg_pre2act = 15 - f;
      issue(3'd1, f % 4);
      meas(3'd2, f % 4, n); check("R2 act->rd", n, f + 1);
      issue(3'd4, f % 4);
      meas(3'd1, f % 4, n); check("R3 pre->act", n, 16 - f);
    end
    cfg_act2rw = 0; cfg_pre2act = 0;

    // R5 / R6 sweep
    for (int f = 0; f < 16; f++) begin
      cfg_rd2pre = f; cfg_rd2wr = (f + 5) % 16;
      issue(3'd1, f % 4);
      issue(3'd2, f % 4);
      meas(3'd3, f % 4, n); check("R6 rd->wr", n, ((f + 5) % 16) > 0 ? (f + 5) % 16 : 1);
      issue(3'd2, f % 4);
      meas(3'd4, f % 4, n); check("R5 rd->pre", n, f > 0 ? f : 1);
      issue(3'd4, f % 4);
    end
    cfg_rd2wr = 0; cfg_rd2pre = 0;

    // R7 sweep
    for (int f = 0; f < 16; f++) begin
      cfg_wr2pre = f;
      issue(3'd1, 3 - f % 4);
      issue(3'd3, 3 - f % 4);
      meas(3'd4, 3 - f % 4, n); check("R7 wr->pre", n, f > 0 ? f : 1);
      issue(3'd4, 3 - f % 4);
    end
    cfg_wr2pre = 0;

    // R4 sweep
    for (int f = 0; f < 16; f++) begin
      cfg_ref2act = f;
      issue(3'd6, 0);
      meas(3'd1, f % 4, n); check("R4 ref->act", n, f > 0 ? 2 * f : 1);
    end
    cfg_ref2act = 0;
    issue(3'd1, 2);
    look(3'd6, 0, v); check("R4 ref blocked by open bank", v, 0);
    cfg_pre2act = 3;
    issue(3'd4, 2);
    meas(3'd6, 0, n); check("R4 ref waits precharge spacing", n, 4);
    cfg_pre2act = 0;

    // R8 bank separation
    issue(3'd1, 0);
    meas(3'd1, 1, n); check("R8 act other bank at once", n, 1);
    issue(3'd1, 1);
    look(3'd2, 2, v); check("R8 rd closed bank", v, 0);
    look(3'd1, 0, v); check("R8 act open bank", v, 0);
    look(3'd2, 1, v); check("R8 rd open bank", v, 1);

    // R9 precharge all
    cfg_rd2pre = 6; cfg_pre2act = 3;
    issue(3'd2, 0);
    meas(3'd5, 0, n); check("R9 prea waits rd->pre", n, 6);
    issue(3'd5, 0);
    for (int b = 0; b < 4; b++) begin
      look(3'd2, b, v); check("R9 prea closes bank", v, 0);
    end
    meas(3'd1, 1, n); check("R9 prea loads pre->act", n, 4);
    cfg_rd2pre = 0; cfg_pre2act = 0;

    // R13 unused codes
    issue(3'd7, 3);
    look(3'd2, 3, v); check("R13 code 7 opens nothing", v, 0);
    look(3'd6, 0, v); check("R13 code 7 keeps ref allowed", v, 1);
    issue(3'd0, 3);
    look(3'd1, 3, v); check("R13 code 0 keeps act allowed", v, 1);

    // R10 / R11 refresh timer
    for (int c = 0; c < 4; c++) begin
      cfg_ref_cnt = c;
      @(negedge clk); cfg_ref_en = 1;
      n = 0;
      do begin @(posedge clk); n++; @(negedge clk); end while (!ref_req && n < 600);
      check("R10 interval", n, (c + 1) * 64);
      repeat (10) @(negedge clk);
      check("R11 request held", ref_req, 1);
      issue(3'd6, 0);
      check("R11 cleared after refresh", ref_req, 0);
      cfg_ref_en = 0;
    end

    // R12 disabled and restart
    cfg_ref_cnt = 0;
    v = 0;
    repeat (200) begin @(negedge clk); if (ref_req) v = 1; end
    check("R12 no request while disabled", v, 0);
    cfg_ref_en = 1;
    repeat (40) @(negedge clk);
    cfg_ref_en = 0;
    @(negedge clk);
    cfg_ref_en = 1;
    n = 0;
    do begin @(posedge clk); n++; @(negedge clk); end while (!ref_req && n < 600);
    check("R12 restart full interval", n, 64);
    cfg_ref_en = 0;

    summary();
  end
endmodule